// File: doc/BRIEF.md
# Tap-Selected Idle Interval Timer

This block keeps a 16-bit count that runs down by one on every instruction-cycle enable. Software can neither read nor load the count. A small select register chooses one of the five upper bits of the count (bit 11 through bit 15) as a tap. Whenever the chosen tap goes from 0 to 1 as the count wraps downward, the block raises an expiry event. The resulting periods are 4,096, 8,192, 16,384, 32,768 or 65,536 enabled cycles.

Each expiry event does three things. It sets a sticky pending flag. It emits a single-clock `idle_exit` pulse that takes the device out of its low-power idle state. When the local enable and the global interrupt enable are both set, the pending flag also drives the interrupt request. The edge detector looks at the output of the tap multiplexer, not at a fixed counter bit. Rewriting the select field can therefore produce a spurious event, and the block keeps that behaviour on purpose.

The pending flag is a two-state machine. In `PS_QUIET` no expiry is outstanding. In `PS_PENDING` an expiry is waiting for software. It has four transitions. QUIET→PENDING happens on an expiry event. PENDING→QUIET happens on a clearing write in a cycle with no expiry event. QUIET→QUIET happens when there is no event. PENDING→PENDING happens when there is no clearing write, or when an event arrives together with a clear.

Top module: `idle_tap_timer`

## Requirements
- R1: While reset is active the select register (address 0) and the control register (address 1) both read 0, and `irq` and `idle_exit` are low. The count is loaded with all ones.
- R2: The count decrements once per clock edge with `cyc_en` high. With the default select of 0, the first expiry comes on the 4,097th enabled edge after reset, and the next one comes 4,096 enabled edges later.
- R3: Select codes 0, 1, 2 and 3 tap count bits 11, 12, 13 and 14, giving 4,096, 8,192, 16,384 and 32,768 cycles. Any code 4 to 7 taps bit 15 and gives 65,536 cycles. From reset, the first expiry arrives on enabled edge 1 + period.
- R4: At address 0, bits [2:0] hold the select code. Bits [7:3] ignore writes and read as 0.
- R5: An expiry sets the pending flag, which reads at address 1 bit 1. The flag stays set until a write to address 1 with bit 1 = 0. Writing 1 to that bit has no effect.
- R6: If an expiry and a clearing write fall on the same clock edge, the pending flag stays set.
- R7: Each expiry produces a `idle_exit` pulse exactly one clock long, whatever the enables are set to.
- R8: `irq` is high exactly when the pending flag, the local enable (address 1 bit 0, read/write) and `gie` are all 1.
- R9: Clock edges with `cyc_en` low neither move the count nor produce an expiry, even if the select changes.
- R10: After a select write, an expiry occurs on the next enabled edge if the newly selected bit is 1 and the previously sampled tap was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable; one count step per high cycle |
| gie | input | 1 | Global interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 = tap select, 1 = control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| idle_exit | output | 1 | One-clock pulse on each expiry; clears the idle state |
| irq | output | 1 | Timer interrupt request |

## Verification
Two things can collide in a single clock: an expiry event that sets the pending flag, and a software write that clears it. The bench first lets one expiry set the flag. It then steps the enable to the edge just before the next expiry and issues the clearing write on exactly that edge. The flag must still read 1 afterwards, and a later clear on its own must drop it. A second kind of overlap is a select write that lands while the tap is changing. This is forced by stalling the enable after bit 11 has gone low and then selecting bit 12, and the bench checks that the spurious expiry appears on the next enabled edge and not before it.

// File: rtl/itm_pkg.sv
package itm_pkg;

    typedef enum logic {
        PS_QUIET   = 1'b0,
        PS_PENDING = 1'b1
    } pend_state_e;

endpackage

// File: rtl/itm_down_counter.sv
module itm_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '1;
        end else if (step) begin
            count <= count - ONE;
        end
    end

    // R2: one decrement per enabled edge
    a_r2_step_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (count == $past(count) - ONE));

    // R9: a stalled cycle leaves the count alone
    a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(count));

endmodule

// File: rtl/itm_tap_edge.sv
module itm_tap_edge #(
    parameter int NUM_TAPS = 5,
    parameter int SEL_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TAPS-1:0] taps,
    output logic                rise
);

    localparam logic [SEL_W-1:0] TOP_CODE = SEL_W'(NUM_TAPS - 1);

    logic [SEL_W-1:0] idx;
    logic             tap_now;
    logic             prev_q;

    // codes at or above the last tap all select the widest period
    always_comb begin
        idx     = (sel >= TOP_CODE) ? TOP_CODE : sel;
        tap_now = taps[idx];
    end

    // history is taken after the multiplexer so a new selection can edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else if (step) begin
            prev_q <= tap_now;
        end
    end

    assign rise = step & tap_now & ~prev_q;

    // R10: after an enabled edge the history matches the tap it sampled
    a_r10_history_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (prev_q == $past(tap_now)));

endmodule

// File: rtl/itm_pend_fsm.sv
module itm_pend_fsm
    import itm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic pend,
    output logic idle_exit
);

    pend_state_e state_q;
    pend_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // event has priority over a clearing write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_QUIET:   if (evt) state_d = PS_PENDING;
            PS_PENDING: if (clr && !evt) state_d = PS_QUIET;
            default:    state_d = PS_QUIET;
        endcase
    end

    always_comb begin
        pend = (state_q == PS_PENDING);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_exit <= 1'b0;
        end else begin
            idle_exit <= evt;
        end
    end

    // R5: pending is sticky until cleared
    a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr) |=> pend);

    // R6: event beats a simultaneous clear
    a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && clr) |=> pend);

    // R7: the wake pulse lasts one clock
    a_r7_exit_single: assert property (@(posedge clk) disable iff (!rst_n)
        idle_exit |=> !idle_exit);

    // R7: a newly set flag always comes with a wake pulse
    a_r7_set_with_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> idle_exit);

endmodule

// File: rtl/idle_tap_timer.sv
module idle_tap_timer #(
    parameter int CNT_W    = 16,
    parameter int TAP_LO   = 11,
    parameter int NUM_TAPS = 5,
    parameter int SEL_W    = 3,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              gie,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              idle_exit,
    output logic              irq
);

    localparam int EN_BIT   = 0;
    localparam int PEND_BIT = 1;
    localparam int RSV_W    = DATA_W - SEL_W;

    logic [CNT_W-1:0]    count;
    logic [NUM_TAPS-1:0] tap_bus;
    logic [SEL_W-1:0]    sel_q;
    logic                en_q;
    logic                rise;
    logic                pend;
    logic                clr;
    logic                unused_rsvd;

    itm_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cyc_en),
        .count (count)
    );

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
        assign tap_bus[i] = count[TAP_LO + i];
    end

    itm_tap_edge #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (cyc_en),
        .sel   (sel_q),
        .taps  (tap_bus),
        .rise  (rise)
    );

    assign clr = reg_wr & reg_addr & ~reg_wdata[PEND_BIT];

    itm_pend_fsm u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (rise),
        .clr       (clr),
        .pend      (pend),
        .idle_exit (idle_exit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else if (reg_wr) begin
            if (!reg_addr) begin
                sel_q <= reg_wdata[SEL_W-1:0];
            end else begin
                en_q <= reg_wdata[EN_BIT];
            end
        end
    end

    assign unused_rsvd = ^reg_wdata[DATA_W-1:SEL_W];

    always_comb begin
        if (!reg_addr) begin
            reg_rdata = {{RSV_W{1'b0}}, sel_q};
        end else begin
            reg_rdata = '0;
            reg_rdata[EN_BIT]   = en_q;
            reg_rdata[PEND_BIT] = pend;
        end
    end

    assign irq = pend & en_q & gie;

    // R4: reserved select bits never read back as 1
    a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_addr |-> (reg_rdata[DATA_W-1:SEL_W] == '0));

    // R9: no wake pulse follows a stalled edge
    a_r9_no_exit_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_en |=> !idle_exit);

endmodule

// File: tb/tb_idle_tap_timer.sv
module tb_idle_tap_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       gie = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       idle_exit;
    logic       irq;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    idle_tap_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_en    (cyc_en),
        .gie       (gie),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .idle_exit (idle_exit),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cyc_en = 1'b0; reg_wr = 1'b0; gie = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // exactly n enabled edges, return at the negedge after the last one
    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_en = 1'b1;
            @(negedge clk);
        end
        cyc_en = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        rd(1'b0, d); check("R1 sel in reset", d, 8'h00);
        rd(1'b1, d); check("R1 ctrl in reset", d, 8'h00);
        check("R1 irq in reset", {7'b0, irq}, 8'h00);
        check("R1 exit in reset", {7'b0, idle_exit}, 8'h00);
        do_reset();
    endtask

    task automatic t_period(input logic [7:0] sel, input int period, input string req);
        logic [7:0] d;
        do_reset();
        wr(1'b0, sel);
        run(period);
        rd(1'b1, d); check({req, " no early expiry"}, d, 8'h00);
        run(1);
        rd(1'b1, d); check({req, " expiry sets pending"}, d, 8'h02);
        check({req, " exit pulse"}, {7'b0, idle_exit}, 8'h01);
        @(negedge clk);
        check("R7 pulse one clock", {7'b0, idle_exit}, 8'h00);
    endtask

    task automatic t_default_and_stall();
        logic [7:0] d;
        do_reset();
        run(4097);
        check("R2 first expiry", {7'b0, idle_exit}, 8'h01);
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R5 clear by write 0", d, 8'h00);
        run(2000);
        repeat (50) @(negedge clk);
        check("R9 stall no pulse", {7'b0, idle_exit}, 8'h00);
        run(2095);
        rd(1'b1, d); check("R2 second not early", d, 8'h00);
        run(1);
        rd(1'b1, d); check("R2 second expiry at 4096", d, 8'h02);
    endtask

    task automatic t_reg_fields();
        logic [7:0] d;
        do_reset();
        wr(1'b0, 8'hFA);
        rd(1'b0, d); check("R4 reserved read 0", d, 8'h02);
        wr(1'b1, 8'h02);
        rd(1'b1, d); check("R5 write 1 no set", d, 8'h00);
    endtask

    task automatic t_collision();
        logic [7:0] d;
        do_reset();
        run(4097);
        run(4095);
        rd(1'b1, d); check("R6 pending before collide", d, 8'h02);
        reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 8'h00; cyc_en = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; cyc_en = 1'b0;
        rd(1'b1, d); check("R6 event wins over clear", d, 8'h02);
        check("R6 exit on collide", {7'b0, idle_exit}, 8'h01);
        wr(1'b1, 8'h00);
        rd(1'b1, d); check("R6 later clear", d, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        do_reset();
        run(4097);
        check("R7 exit with enables off", {7'b0, idle_exit}, 8'h01);
        check("R8 no irq enables off", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h03);
        rd(1'b1, d); check("R8 enable kept pending", d, 8'h03);
        check("R8 no irq without gie", {7'b0, irq}, 8'h00);
        gie = 1'b1; #1;
        check("R8 irq all set", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h02);
        check("R8 irq off local en 0", {7'b0, irq}, 8'h00);
        wr(1'b1, 8'h03);
        check("R8 irq back", {7'b0, irq}, 8'h01);
        wr(1'b1, 8'h01);
        check("R8 irq off when cleared", {7'b0, irq}, 8'h00);
        gie = 1'b0;
    endtask

    task automatic t_spurious();
        logic [7:0] d;
        do_reset();
        run(2049);
        wr(1'b0, 8'h01);
        repeat (5) @(negedge clk);
        rd(1'b1, d); check("R9 no event while stalled", d, 8'h00);
        run(1);
        rd(1'b1, d); check("R10 spurious expiry", d, 8'h02);
        check("R10 spurious exit", {7'b0, idle_exit}, 8'h01);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_default_and_stall();
                t_reg_fields();
                t_period(8'h01, 8192, "R3 sel1");
                t_period(8'h03, 32768, "R3 sel3");
                t_period(8'h06, 65536, "R3 sel6");
                t_collision();
                t_irq();
                t_spurious();
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_checks++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule